// File: doc/BRIEF.md
# Serial DAC Receive Front End

This block is the digital receive side of a serial-input digital-to-analog converter. It runs on a fast system clock and oversamples the serial clock, the active-low frame select, the serial data line, the active-low load strobe and the active-low clear line. All five pass through two-flop synchronizers. While the frame select is low, the block shifts serial bits into a 16-bit shift register, most significant bit first. A frame counts only if it has exactly 16 capture edges and was preceded by a long enough idle gap. A good frame is then copied into a holding register, or, if it carries the control tag, into the configuration bits.

The value reaches the DAC output register in one of two ways. In synchronous mode it is copied there as the frame closes. In asynchronous mode it waits for a load strobe that was held low long enough. A low level on the clear line forces the output register to zero. The serial output gives out the previous frame's bits for daisy-chaining. A flag tells the pad which drive strength is selected.

Control frames have the top nibble 4'b1101. Their low bits select:
- the capture edge,
- the update mode,
- the serial output drive strength.

A new setting takes effect from the next frame.

Top module: `sdac_rx`

## Requirements
- R1: After synchronous reset, `dac_q` is 0, `frame_ok`, `frame_err`, `sdo` and `sdo_strong` are 0, capture is on the falling serial clock edge, and the update mode is asynchronous.
- R2: A frame runs from a fall of `sync_n_i` to its rise. A frame with exactly 16 capture edges, whose top nibble is not 4'b1101, is a data frame. It is taken MSB first (first bit is bit 15), raises `frame_ok` for one cycle and loads the holding register.
- R3: A good frame whose bits [15:12] are 4'b1101 is a control frame. Bit 0 = 1 selects rising-edge capture, bit 1 = 1 selects synchronous update, and bit 2 = 1 drives `sdo_strong` high. A control frame leaves the holding register and `dac_q` unchanged.
- R4: With rising-edge capture selected, bits are taken on rising serial clock edges, and falling edges are not counted.
- R5: In synchronous mode, `dac_q` takes a data frame's word one clock after `frame_ok`.
- R6: In asynchronous mode, a data frame does not change `dac_q`. A low pulse on `ldac_n_i` of at least MIN_LOAD system clocks copies the holding register to `dac_q` when the pulse ends.
- R7: A load pulse shorter than MIN_LOAD clocks is ignored. A load pulse in synchronous mode is ignored.
- R8: While the synchronized `clr_n_i` is low, `dac_q` is forced to 0. Clear wins over both load paths.
- R9: A frame with fewer or more than 16 capture edges raises `frame_err` for one cycle and leaves the holding register unchanged.
- R10: If `sync_n_i` was high for fewer than MIN_GAP clocks before a frame starts, that frame raises `frame_err` and is discarded.
- R11: `sdo` presents the previous frame's contents MSB first, advancing one bit per capture edge.
- R12: `frame_ok` and `frame_err` are single-cycle pulses, and they are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4 times the serial clock rate |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sync_n_i | input | 1 | Active-low frame select |
| sdin_i | input | 1 | Serial data in |
| ldac_n_i | input | 1 | Active-low load strobe |
| clr_n_i | input | 1 | Active-low clear of the output register |
| dac_q | output | 16 | DAC output register |
| frame_ok | output | 1 | One-cycle pulse for an accepted frame |
| frame_err | output | 1 | One-cycle pulse for a rejected frame |
| sdo | output | 1 | Serial data out, previous frame |
| sdo_strong | output | 1 | High selects strong drive on the serial output pad |

## Verification
Faults in the frame side show up at the ports within a few clocks of the frame-select rise:
- A wrong bit count, or a missed gap error, gives a `frame_err` or `frame_ok` pulse of the wrong kind.
- A mis-ordered shift register gives a wrong `dac_q` value in synchronous mode.

A wrong holding register is hidden in asynchronous mode until a later load strobe exposes it. For that reason, rejected frames are followed by clear-then-load sequences. A wrong edge-select or drive configuration can only be seen on the next frame: either bits are taken on the wrong edge, or `sdo_strong` has the wrong level. A corrupted shift register also shows up bit by bit on `sdo` during the following frame.

// File: rtl/sdac_rx_pkg.sv
package sdac_rx_pkg;
  localparam logic [3:0] CTRL_TAG = 4'b1101;

  typedef struct packed {
    logic sdo_strong;
    logic sync_update;
    logic capture_rise;
  } sdac_cfg_t;
endpackage

// File: rtl/sdac_rx_sync.sv
module sdac_rx_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= RST_VAL;
        else     stg[i] <= d;
      end
    end else begin : g_rest
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= RST_VAL;
        else     stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sdac_rx_frame.sv
module sdac_rx_frame #(
  parameter int WORD_W  = 16,
  parameter int MIN_GAP = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s_sclk,
  input  logic              s_sync_n,
  input  logic              s_sdin,
  input  logic              capture_rise,
  output logic              frame_ok,
  output logic              frame_err,
  output logic [WORD_W-1:0] word_q,
  output logic              sdo
);
  localparam int CW = $clog2(WORD_W + 2);
  localparam int GW = $clog2(MIN_GAP + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(WORD_W);
  localparam logic [CW-1:0] CNT_SAT  = CW'(WORD_W + 1);
  localparam logic [GW-1:0] GAP_MIN  = GW'(MIN_GAP);

  logic              prev_sclk, prev_sync;
  logic [WORD_W-1:0] shreg;
  logic [CW-1:0]     bit_cnt;
  logic [GW-1:0]     gap_cnt;
  logic              gap_bad;
  logic              sync_fall, sync_rise, cap_edge;

  assign sync_fall = prev_sync & ~s_sync_n;
  assign sync_rise = ~prev_sync & s_sync_n;
  assign cap_edge  = capture_rise ? (~prev_sclk & s_sclk) : (prev_sclk & ~s_sclk);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_sclk <= 1'b1;
      prev_sync <= 1'b1;
      shreg     <= '0;
      bit_cnt   <= '0;
      gap_cnt   <= GAP_MIN;
      gap_bad   <= 1'b0;
      frame_ok  <= 1'b0;
      frame_err <= 1'b0;
      word_q    <= '0;
      sdo       <= 1'b0;
    end else begin
      prev_sclk <= s_sclk;
      prev_sync <= s_sync_n;
      frame_ok  <= 1'b0;
      frame_err <= 1'b0;
      sdo       <= shreg[WORD_W-1];

      if (!s_sync_n)               gap_cnt <= '0;
      else if (gap_cnt != GAP_MIN) gap_cnt <= gap_cnt + 1'b1;

      if (sync_fall) begin
        bit_cnt <= '0;
        gap_bad <= (gap_cnt < GAP_MIN);
      end else if (!s_sync_n && cap_edge) begin
        shreg <= {shreg[WORD_W-2:0], s_sdin};
        if (bit_cnt != CNT_SAT) bit_cnt <= bit_cnt + 1'b1;
      end

      if (sync_rise) begin
        if (bit_cnt == CNT_FULL && !gap_bad) begin
          frame_ok <= 1'b1;
          word_q   <= shreg;
        end else begin
          frame_err <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sdac_rx_update.sv
module sdac_rx_update
  import sdac_rx_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int MIN_LOAD = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_ok,
  input  logic [WORD_W-1:0] word_q,
  input  logic              s_ldac_n,
  input  logic              s_clr_n,
  output sdac_cfg_t         cfg_q,
  output logic [WORD_W-1:0] hold_q,
  output logic [WORD_W-1:0] dac_q,
  output logic              load_go
);
  localparam int LW = $clog2(MIN_LOAD + 1);
  localparam logic [LW-1:0] LOAD_MIN = LW'(MIN_LOAD);

  logic          prev_ldac;
  logic [LW-1:0] low_cnt;
  logic          is_ctrl, data_ok;

  assign is_ctrl = (word_q[WORD_W-1 -: 4] == CTRL_TAG);
  assign data_ok = frame_ok & ~is_ctrl;
  assign load_go = s_ldac_n & ~prev_ldac & (low_cnt >= LOAD_MIN) & ~cfg_q.sync_update;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_ldac <= 1'b1;
      low_cnt   <= '0;
    end else begin
      prev_ldac <= s_ldac_n;
      if (s_ldac_n)               low_cnt <= '0;
      else if (low_cnt != LOAD_MIN) low_cnt <= low_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      hold_q <= '0;
    end else if (frame_ok) begin
      if (is_ctrl) begin
        cfg_q.capture_rise <= word_q[0];
        cfg_q.sync_update  <= word_q[1];
        cfg_q.sdo_strong   <= word_q[2];
      end else begin
        hold_q <= word_q;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                               dac_q <= '0;
    else if (!s_clr_n)                     dac_q <= '0;
    else if (data_ok && cfg_q.sync_update) dac_q <= word_q;
    else if (load_go)                      dac_q <= hold_q;
  end
endmodule

// File: rtl/sdac_rx.sv
module sdac_rx
  import sdac_rx_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int MIN_GAP  = 4,
  parameter int MIN_LOAD = 3,
  parameter int STAGES   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_i,
  input  logic              sync_n_i,
  input  logic              sdin_i,
  input  logic              ldac_n_i,
  input  logic              clr_n_i,
  output logic [WORD_W-1:0] dac_q,
  output logic              frame_ok,
  output logic              frame_err,
  output logic              sdo,
  output logic              sdo_strong
);
  logic [4:0]        s_bus;
  logic              s_sclk, s_sync_n, s_sdin, s_ldac_n, s_clr_n;
  logic [WORD_W-1:0] word_w, hold_w;
  logic              load_go;
  sdac_cfg_t         cfg_w;

  sdac_rx_sync #(.W(5), .STAGES(STAGES), .RST_VAL(5'b11011)) u_sync (
    .clk(clk), .rst(rst),
    .d({sclk_i, sync_n_i, sdin_i, ldac_n_i, clr_n_i}),
    .q(s_bus)
  );
  assign {s_sclk, s_sync_n, s_sdin, s_ldac_n, s_clr_n} = s_bus;

  sdac_rx_frame #(.WORD_W(WORD_W), .MIN_GAP(MIN_GAP)) u_frame (
    .clk(clk), .rst(rst),
    .s_sclk(s_sclk), .s_sync_n(s_sync_n), .s_sdin(s_sdin),
    .capture_rise(cfg_w.capture_rise),
    .frame_ok(frame_ok), .frame_err(frame_err),
    .word_q(word_w), .sdo(sdo)
  );

  sdac_rx_update #(.WORD_W(WORD_W), .MIN_LOAD(MIN_LOAD)) u_upd (
    .clk(clk), .rst(rst),
    .frame_ok(frame_ok), .word_q(word_w),
    .s_ldac_n(s_ldac_n), .s_clr_n(s_clr_n),
    .cfg_q(cfg_w), .hold_q(hold_w), .dac_q(dac_q), .load_go(load_go)
  );

  assign sdo_strong = cfg_w.sdo_strong;
endmodule

// File: rtl/sdac_rx_chk.sv
module sdac_rx_chk
  import sdac_rx_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              frame_ok,
  input logic              frame_err,
  input logic [WORD_W-1:0] dac_q,
  input logic [WORD_W-1:0] word_q,
  input logic [WORD_W-1:0] hold_q,
  input logic              clr_s,
  input logic              load_go,
  input logic              sync_update
);
  logic is_data;
  assign is_data = (word_q[WORD_W-1 -: 4] != CTRL_TAG);

  assert_one_outcome_R12: assert property (@(posedge clk) disable iff (rst)
    $onehot0({frame_ok, frame_err}));

  assert_ok_pulse_R12: assert property (@(posedge clk) disable iff (rst)
    frame_ok |=> !frame_ok);

  assert_err_pulse_R12: assert property (@(posedge clk) disable iff (rst)
    frame_err |=> !frame_err);

  assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
    !clr_s |=> (dac_q == '0));

  assert_hold_load_R2: assert property (@(posedge clk) disable iff (rst)
    (frame_ok && is_data) |=> (hold_q == $past(word_q)));

  assert_sync_update_R5: assert property (@(posedge clk) disable iff (rst)
    (frame_ok && is_data && sync_update && clr_s) |=> (dac_q == $past(word_q)));

  assert_async_no_update_R6: assert property (@(posedge clk) disable iff (rst)
    (frame_ok && !sync_update && clr_s && !load_go) |=> $stable(dac_q));

  assert_dac_source_R6: assert property (@(posedge clk) disable iff (rst)
    !$stable(dac_q) |-> ($past(frame_ok) || $past(load_go) || !$past(clr_s)));
endmodule

bind sdac_rx sdac_rx_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst(rst),
  .frame_ok(frame_ok), .frame_err(frame_err),
  .dac_q(dac_q), .word_q(word_w), .hold_q(hold_w),
  .clr_s(s_clr_n), .load_go(load_go),
  .sync_update(cfg_w.sync_update)
);

// File: tb/sdac_rx_test.sv
`timescale 1ns/1ps
module sdac_rx_test;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk_i = 1'b1, sync_n_i = 1'b1, sdin_i = 1'b0, ldac_n_i = 1'b1, clr_n_i = 1'b1;
  logic [15:0] dac_q;
  logic frame_ok, frame_err, sdo, sdo_strong;

  int checks = 0, errors = 0;
  int ok_cnt = 0, err_cnt = 0, both_cnt = 0;
  bit rising = 1'b0;

  always #4 clk = ~clk;

  sdac_rx uut (
    .clk(clk), .rst(rst), .sclk_i(sclk_i), .sync_n_i(sync_n_i), .sdin_i(sdin_i),
    .ldac_n_i(ldac_n_i), .clr_n_i(clr_n_i), .dac_q(dac_q), .frame_ok(frame_ok),
    .frame_err(frame_err), .sdo(sdo), .sdo_strong(sdo_strong)
  );

  always @(posedge clk) begin
    if (frame_ok) ok_cnt <= ok_cnt + 1;
    if (frame_err) err_cnt <= err_cnt + 1;
    if (frame_ok && frame_err) both_cnt <= both_cnt + 1;
  end

  // {word, edges, short gap, expect ok, expect dac} in synchronous mode
  localparam logic [38:0] VEC [8] = '{
    {16'hA5C3, 5'd16, 1'b0, 1'b1, 16'hA5C3},
    {16'h0001, 5'd16, 1'b0, 1'b1, 16'h0001},
    {16'h1234, 5'd15, 1'b0, 1'b0, 16'h0001},
    {16'hFFFF, 5'd16, 1'b0, 1'b1, 16'hFFFF},
    {16'h5555, 5'd17, 1'b0, 1'b0, 16'hFFFF},
    {16'h0F0F, 5'd16, 1'b1, 1'b0, 16'hFFFF},
    {16'h8000, 5'd16, 1'b0, 1'b1, 16'h8000},
    {16'h7FFE, 5'd16, 1'b0, 1'b1, 16'h7FFE}
  };

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send_frame(input logic [15:0] w, input int n, input bit short_gap,
                            input bit chk_sdo, input logic [15:0] prev);
    int sdo_bad = 0;
    if (short_gap) begin
      sync_n_i = 1'b0; wait_clk(1);
      sync_n_i = 1'b1; wait_clk(2);
    end
    sync_n_i = 1'b0;
    for (int i = 0; i < n; i++) begin
      sdin_i = (i < 16) ? w[15-i] : 1'b0;
      wait_clk(HALF);
      if (chk_sdo && i < 16 && sdo !== prev[15-i]) sdo_bad++;
      sclk_i = rising;
      wait_clk(HALF);
      sclk_i = ~rising;
    end
    wait_clk(HALF);
    sync_n_i = 1'b1;
    wait_clk(12);
    if (chk_sdo) check("R11 sdo bit mismatches", sdo_bad, 0);
  endtask

  task automatic ldac_pulse(input int len);
    ldac_n_i = 1'b0; wait_clk(len);
    ldac_n_i = 1'b1; wait_clk(8);
  endtask

  task automatic clr_pulse(input int len);
    clr_n_i = 1'b0; wait_clk(len);
    clr_n_i = 1'b1; wait_clk(6);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int ok0, err0;
    wait_clk(5);
    rst = 1'b0;
    wait_clk(4);
    check("R1 dac reset", dac_q, 0);
    check("R1 ok/err reset", {frame_ok, frame_err}, 0);
    check("R1 sdo reset", {sdo, sdo_strong}, 0);

    // R3: control frame selecting synchronous update, falling capture
    ok0 = ok_cnt;
    send_frame(16'hD002, 16, 1'b0, 1'b0, 16'h0);
    check("R3 control frame accepted", ok_cnt - ok0, 1);
    check("R3 control leaves dac", dac_q, 0);

    // R2 R5 R9 R10: vector table in synchronous mode
    foreach (VEC[k]) begin
      ok0 = ok_cnt; err0 = err_cnt;
      send_frame(VEC[k][38:23], int'(VEC[k][22:18]), VEC[k][17], 1'b0, 16'h0);
      check($sformatf("R2/R9/R10 vec%0d ok pulses", k), ok_cnt - ok0, {31'd0, VEC[k][16]});
      check($sformatf("R9/R10 vec%0d err seen", k), (err_cnt > err0), !VEC[k][16]);
      check($sformatf("R5 vec%0d dac", k), dac_q, {16'd0, VEC[k][15:0]});
    end

    // R8 clear, R7 load ignored in synchronous mode
    clr_pulse(3);
    check("R8 clear", dac_q, 0);
    ldac_pulse(6);
    check("R7 load ignored in sync mode", dac_q, 0);

    // back to asynchronous mode
    send_frame(16'hD000, 16, 1'b0, 1'b0, 16'h0);
    check("R3 control keeps dac", dac_q, 0);

    send_frame(16'h1357, 16, 1'b0, 1'b0, 16'h0);
    check("R6 no update at frame end", dac_q, 0);
    ldac_pulse(2);
    check("R7 short load ignored", dac_q, 0);
    ldac_pulse(6);
    check("R6 load copies holding", dac_q, 16'h1357);

    err0 = err_cnt;
    send_frame(16'h2468, 15, 1'b0, 1'b0, 16'h0);
    check("R9 short frame rejected", err_cnt - err0, 1);
    clr_pulse(3);
    ldac_pulse(6);
    check("R9 holding unchanged", dac_q, 16'h1357);

    clr_n_i = 1'b0;
    wait_clk(3);
    ldac_pulse(6);
    check("R8 clear beats load", dac_q, 0);
    clr_n_i = 1'b1;
    wait_clk(6);

    // R4 rising-edge capture
    send_frame(16'hD001, 16, 1'b0, 1'b0, 16'h0);
    rising = 1'b1;
    sclk_i = 1'b0;
    wait_clk(6);
    ok0 = ok_cnt;
    send_frame(16'hBEEF, 16, 1'b0, 1'b0, 16'h0);
    check("R4 rising frame accepted", ok_cnt - ok0, 1);
    ldac_pulse(6);
    check("R4 rising capture value", dac_q, 16'hBEEF);

    send_frame(16'hD005, 16, 1'b0, 1'b0, 16'h0);
    check("R3 strong drive flag", sdo_strong, 1);

    // R11: sdo replays the previous frame
    send_frame(16'h0123, 16, 1'b0, 1'b1, 16'hD005);
    ldac_pulse(6);
    check("R11 frame after sdo check", dac_q, 16'h0123);

    check("R12 ok and err never together", both_cnt, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule